// File: doc/BRIEF.md
# Speculative Issue Window with One-Cycle Bypass Marks

This block is the scheduling window of an out-of-order core. It holds a fixed number of entries. Each entry carries an operation code, a destination tag, two source tags, a ready flag and a bypass flag per source, and an issued flag. Every cycle the window picks up to `ISSUE_WIDTH` entries that have both sources ready and have not issued yet. The lowest entry index wins. The picked entries go out on the issue slots. At the same clock edge their destination tags are broadcast to every waiting source. A source that matches sets its ready flag. It also raises a bypass flag, which lasts exactly one cycle and tells the read stage that the operand will come from the forwarding network rather than from the register file.

Issue is speculative with respect to register-file bank ports. When the bank arbiter downstream finds a port conflict, it raises a repair command that names the conflicting entries. The window then does three things:
- It withdraws those entries, together with the whole group that issued in the cycle just before the repair, so that all of them can issue again.
- It drops the ready flags that those withdrawn producers had granted to their consumers.
- It issues nothing in the repair cycle.

Allocation writes a supplied free index. Entries leave the window only through an explicit retire command.

Top module: `issue_window`

## Requirements
- R1: After reset, no entry is valid and all issue slots are invalid.
- R2: An entry allocated with both source-ready inputs high appears on an issue slot in the cycle after allocation. The slot carries its index, its operation code and its destination tag.
- R3: Each cycle, up to `ISSUE_WIDTH` eligible entries are issued. An entry is eligible when it is valid, has not issued, and has both sources ready. Slot k carries the k-th lowest eligible index. Valid slots are packed from slot 0 upward.
- R4: An issued entry is not issued again unless a repair withdraws it.
- R5: When an entry issues, every valid source whose tag equals its destination tag becomes ready at the next edge. The consumer can issue in the following cycle.
- R6: A source's bypass bit (`issueBypA`/`issueBypB`, bit k for slot k) is 1 only when that source was woken by a producer that issued in the immediately preceding cycle. In any later cycle it reads 0.
- R7: During a cycle with `repairValid` high, no slot is valid. The entries named in `repairMask` (bit e names entry e), plus every entry issued in the previous cycle, lose their issued flag, keep their tags, and may be selected again from the next cycle on.
- R8: In a repair cycle, every source whose tag equals the destination tag of a withdrawn valid entry loses its ready flag and its bypass flag. It stays ineligible until that producer issues again.
- R9: A retired entry becomes invalid and never appears on an issue slot again until it is reallocated.
- R10: A source written by an allocation in the same cycle that a matching producer issues is captured as ready, with its bypass bit set for the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| allocValid | input | 1 | Write a new entry this cycle |
| allocIdx | input | IDX_W | Free entry index to write |
| allocOp | input | OP_W | Operation code |
| allocDst | input | TAG_W | Destination tag |
| allocSrcA | input | TAG_W | First source tag |
| allocRdyA | input | 1 | First source already available |
| allocSrcB | input | TAG_W | Second source tag |
| allocRdyB | input | 1 | Second source already available |
| retireValid | input | 1 | Free an entry this cycle |
| retireIdx | input | IDX_W | Entry to free |
| repairValid | input | 1 | Bank-conflict repair command |
| repairMask | input | NUM_ENTRIES | Conflicting entries, one bit per entry |
| issueValid | output | ISSUE_WIDTH | Slot k holds an issued entry |
| issueIdx | output | ISSUE_WIDTH*IDX_W | Entry index per slot |
| issueOp | output | ISSUE_WIDTH*OP_W | Operation code per slot |
| issueDst | output | ISSUE_WIDTH*TAG_W | Destination tag per slot |
| issueBypA | output | ISSUE_WIDTH | First source comes from forwarding |
| issueBypB | output | ISSUE_WIDTH | Second source comes from forwarding |

## Verification
The assertions take the inputs to be well formed:
- allocation targets only indices that hold no live entry;
- a retire and an allocation to the same index never share a cycle;
- live producers carry distinct destination tags;
- a repair arrives in the cycle after the conflicting group's successor issued.

Under these assumptions, slot order, the repair blackout, the link between a bypass bit and issue in the preceding cycle, and the absence of duplicate or retired issues all follow from the design. The stimulus keeps to these rules. It reuses an index only after retiring it in an earlier cycle. It gives every entry the destination tag 32 plus its index. It raises each repair right after a cycle with a known issue group.

// File: rtl/iw_pkg.sv
package iw_pkg;

  // Per-cycle strobes passed from control to datapath
  typedef struct packed {
    logic selectEn;  // normal selection cycle
    logic wakeEn;    // broadcast granted destination tags
    logic killEn;    // apply repair kill and ready clearing
  } iwStrobe_t;

endpackage

// File: rtl/iw_ctrl.sv
module iw_ctrl
  import iw_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned ISSUE_WIDTH = 4,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_ENTRIES-1:0]                eligMask,
  input  logic                                  repairValid,
  input  logic [NUM_ENTRIES-1:0]                repairMask,
  output iwStrobe_t                             strobe,
  output logic [NUM_ENTRIES-1:0]                grantMask,
  output logic [NUM_ENTRIES-1:0]                killMask,
  output logic [ISSUE_WIDTH-1:0]                slotValid,
  output logic [ISSUE_WIDTH-1:0][IDX_W-1:0]     slotIdx
);

  logic [NUM_ENTRIES-1:0] lastGrant;
  logic [ISSUE_WIDTH:0][NUM_ENTRIES-1:0] remain;

  always_comb begin
    strobe.selectEn = ~repairValid;
    strobe.wakeEn   = ~repairValid;
    strobe.killEn   = repairValid;
  end

  assign remain[0] = strobe.selectEn ? eligMask : '0;

  // Cascaded lowest-index pickers, one per issue slot
  for (genvar s = 0; s < ISSUE_WIDTH; s++) begin : g_slot
    logic [NUM_ENTRIES-1:0] pickOh;
    logic [IDX_W-1:0]       pickIdx;

    always_comb begin
      pickOh  = '0;
      pickIdx = '0;
      for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
        if (remain[s][e]) begin
          pickOh  = NUM_ENTRIES'(1) << e;
          pickIdx = IDX_W'(e);
        end
      end
    end

    assign remain[s+1]  = remain[s] & ~pickOh;
    assign slotValid[s] = |remain[s];
    assign slotIdx[s]   = pickIdx;
  end

  assign grantMask = remain[0] & ~remain[ISSUE_WIDTH];

  // The group issued one cycle before the repair is also withdrawn
  assign killMask = strobe.killEn ? (repairMask | lastGrant) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastGrant <= '0;
    end else begin
      lastGrant <= grantMask;
    end
  end

endmodule

// File: rtl/iw_datapath.sv
module iw_datapath
  import iw_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned ISSUE_WIDTH = 4,
  parameter int unsigned OP_W        = 4,
  parameter int unsigned TAG_W       = 6,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              allocValid,
  input  logic [IDX_W-1:0]                  allocIdx,
  input  logic [OP_W-1:0]                   allocOp,
  input  logic [TAG_W-1:0]                  allocDst,
  input  logic [TAG_W-1:0]                  allocSrcA,
  input  logic                              allocRdyA,
  input  logic [TAG_W-1:0]                  allocSrcB,
  input  logic                              allocRdyB,
  input  logic                              retireValid,
  input  logic [IDX_W-1:0]                  retireIdx,
  input  iwStrobe_t                         strobe,
  input  logic [NUM_ENTRIES-1:0]            grantMask,
  input  logic [NUM_ENTRIES-1:0]            killMask,
  input  logic [ISSUE_WIDTH-1:0]            slotValid,
  input  logic [ISSUE_WIDTH-1:0][IDX_W-1:0] slotIdx,
  output logic [NUM_ENTRIES-1:0]            eligMask,
  output logic [ISSUE_WIDTH-1:0][OP_W-1:0]  slotOp,
  output logic [ISSUE_WIDTH-1:0][TAG_W-1:0] slotDst,
  output logic [ISSUE_WIDTH-1:0]            slotBypA,
  output logic [ISSUE_WIDTH-1:0]            slotBypB
);

  logic [NUM_ENTRIES-1:0] valid, issued, rdyA, rdyB, bypA, bypB;
  logic [OP_W-1:0]  opTag  [NUM_ENTRIES];
  logic [TAG_W-1:0] dstTag [NUM_ENTRIES];
  logic [TAG_W-1:0] srcA   [NUM_ENTRIES];
  logic [TAG_W-1:0] srcB   [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0] wakeA, wakeB, clrA, clrB;
  logic allocHitA, allocHitB;

  assign eligMask = valid & ~issued & rdyA & rdyB;

  // Tag compare: wakeup from granted producers, clearing from killed ones
  always_comb begin
    wakeA = '0;
    wakeB = '0;
    clrA  = '0;
    clrB  = '0;
    allocHitA = 1'b0;
    allocHitB = 1'b0;
    for (int k = 0; k < NUM_ENTRIES; k++) begin
      if (strobe.wakeEn && grantMask[k]) begin
        if (allocSrcA == dstTag[k]) allocHitA = 1'b1;
        if (allocSrcB == dstTag[k]) allocHitB = 1'b1;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
          if (srcA[e] == dstTag[k]) wakeA[e] = 1'b1;
          if (srcB[e] == dstTag[k]) wakeB[e] = 1'b1;
        end
      end
      if (strobe.killEn && killMask[k] && valid[k]) begin
        for (int e = 0; e < NUM_ENTRIES; e++) begin
          if (srcA[e] == dstTag[k]) clrA[e] = 1'b1;
          if (srcB[e] == dstTag[k]) clrB[e] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= '0;
      issued <= '0;
      rdyA   <= '0;
      rdyB   <= '0;
      bypA   <= '0;
      bypB   <= '0;
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        opTag[e]  <= '0;
        dstTag[e] <= '0;
        srcA[e]   <= '0;
        srcB[e]   <= '0;
      end
    end else begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if (allocValid && (allocIdx == IDX_W'(e))) begin
          valid[e]  <= 1'b1;
          issued[e] <= 1'b0;
          opTag[e]  <= allocOp;
          dstTag[e] <= allocDst;
          srcA[e]   <= allocSrcA;
          srcB[e]   <= allocSrcB;
          rdyA[e]   <= allocRdyA | allocHitA;
          rdyB[e]   <= allocRdyB | allocHitB;
          bypA[e]   <= allocHitA;
          bypB[e]   <= allocHitB;
        end else begin
          if (retireValid && (retireIdx == IDX_W'(e))) valid[e] <= 1'b0;
          if (killMask[e]) issued[e] <= 1'b0;
          else if (grantMask[e]) issued[e] <= 1'b1;
          if (clrA[e]) begin
            rdyA[e] <= 1'b0;
            bypA[e] <= 1'b0;
          end else begin
            if (wakeA[e]) rdyA[e] <= 1'b1;
            bypA[e] <= wakeA[e];
          end
          if (clrB[e]) begin
            rdyB[e] <= 1'b0;
            bypB[e] <= 1'b0;
          end else begin
            if (wakeB[e]) rdyB[e] <= 1'b1;
            bypB[e] <= wakeB[e];
          end
        end
      end
    end
  end

  // Read out the fields of the selected entries
  always_comb begin
    for (int s = 0; s < ISSUE_WIDTH; s++) begin
      slotOp[s]   = '0;
      slotDst[s]  = '0;
      slotBypA[s] = 1'b0;
      slotBypB[s] = 1'b0;
      if (slotValid[s]) begin
        slotOp[s]   = opTag[slotIdx[s]];
        slotDst[s]  = dstTag[slotIdx[s]];
        slotBypA[s] = bypA[slotIdx[s]];
        slotBypB[s] = bypB[slotIdx[s]];
      end
    end
  end

endmodule

// File: rtl/issue_window.sv
module issue_window
  import iw_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned ISSUE_WIDTH = 4,
  parameter int unsigned OP_W        = 4,
  parameter int unsigned TAG_W       = 6,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           allocValid,
  input  logic [IDX_W-1:0]               allocIdx,
  input  logic [OP_W-1:0]                allocOp,
  input  logic [TAG_W-1:0]               allocDst,
  input  logic [TAG_W-1:0]               allocSrcA,
  input  logic                           allocRdyA,
  input  logic [TAG_W-1:0]               allocSrcB,
  input  logic                           allocRdyB,
  input  logic                           retireValid,
  input  logic [IDX_W-1:0]               retireIdx,
  input  logic                           repairValid,
  input  logic [NUM_ENTRIES-1:0]         repairMask,
  output logic [ISSUE_WIDTH-1:0]         issueValid,
  output logic [ISSUE_WIDTH*IDX_W-1:0]   issueIdx,
  output logic [ISSUE_WIDTH*OP_W-1:0]    issueOp,
  output logic [ISSUE_WIDTH*TAG_W-1:0]   issueDst,
  output logic [ISSUE_WIDTH-1:0]         issueBypA,
  output logic [ISSUE_WIDTH-1:0]         issueBypB
);

  iwStrobe_t                        strobe;
  logic [NUM_ENTRIES-1:0]           eligMask, grantMask, killMask;
  logic [ISSUE_WIDTH-1:0]           slotValid;
  logic [ISSUE_WIDTH-1:0][IDX_W-1:0] slotIdx;
  logic [ISSUE_WIDTH-1:0][OP_W-1:0]  slotOp;
  logic [ISSUE_WIDTH-1:0][TAG_W-1:0] slotDst;

  iw_ctrl #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .ISSUE_WIDTH(ISSUE_WIDTH)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .eligMask   (eligMask),
    .repairValid(repairValid),
    .repairMask (repairMask),
    .strobe     (strobe),
    .grantMask  (grantMask),
    .killMask   (killMask),
    .slotValid  (slotValid),
    .slotIdx    (slotIdx)
  );

  iw_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .ISSUE_WIDTH(ISSUE_WIDTH),
    .OP_W       (OP_W),
    .TAG_W      (TAG_W)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .allocValid (allocValid),
    .allocIdx   (allocIdx),
    .allocOp    (allocOp),
    .allocDst   (allocDst),
    .allocSrcA  (allocSrcA),
    .allocRdyA  (allocRdyA),
    .allocSrcB  (allocSrcB),
    .allocRdyB  (allocRdyB),
    .retireValid(retireValid),
    .retireIdx  (retireIdx),
    .strobe     (strobe),
    .grantMask  (grantMask),
    .killMask   (killMask),
    .slotValid  (slotValid),
    .slotIdx    (slotIdx),
    .eligMask   (eligMask),
    .slotOp     (slotOp),
    .slotDst    (slotDst),
    .slotBypA   (issueBypA),
    .slotBypB   (issueBypB)
  );

  assign issueValid = slotValid;
  assign issueIdx   = slotIdx;
  assign issueOp    = slotOp;
  assign issueDst   = slotDst;

endmodule

// File: rtl/issue_window_chk.sv
module issue_window_chk #(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned ISSUE_WIDTH = 4,
  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         allocValid,
  input logic [IDX_W-1:0]             allocIdx,
  input logic                         retireValid,
  input logic [IDX_W-1:0]             retireIdx,
  input logic                         repairValid,
  input logic [ISSUE_WIDTH-1:0]       issueValid,
  input logic [ISSUE_WIDTH*IDX_W-1:0] issueIdx,
  input logic [ISSUE_WIDTH-1:0]       issueBypA,
  input logic [ISSUE_WIDTH-1:0]       issueBypB
);

  // R3
  slots_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((issueValid & (issueValid + 1'b1)) == '0));

  // R7
  repair_blackout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    repairValid |-> (issueValid == '0));

  for (genvar k = 0; k < ISSUE_WIDTH; k++) begin : g_k
    if (k > 0) begin : g_ord
      // R3
      slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issueValid[k] |-> (issueIdx[k*IDX_W +: IDX_W] > issueIdx[(k-1)*IDX_W +: IDX_W]));
    end

    // R6
    bypass_recent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issueValid[k] && (issueBypA[k] || issueBypB[k])) |-> $past(|issueValid));

    // R9
    retired_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (retireValid && !(allocValid && allocIdx == retireIdx)) |=>
        !(issueValid[k] && issueIdx[k*IDX_W +: IDX_W] == $past(retireIdx)));

    for (genvar m = 0; m < ISSUE_WIDTH; m++) begin : g_m
      // R4
      no_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(repairValid) && !$past(allocValid) && $past(issueValid[m]) && issueValid[k])
          |-> (issueIdx[k*IDX_W +: IDX_W] != $past(issueIdx[m*IDX_W +: IDX_W])));
    end
  end

endmodule

bind issue_window issue_window_chk #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .ISSUE_WIDTH(ISSUE_WIDTH)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .allocValid (allocValid),
  .allocIdx   (allocIdx),
  .retireValid(retireValid),
  .retireIdx  (retireIdx),
  .repairValid(repairValid),
  .issueValid (issueValid),
  .issueIdx   (issueIdx),
  .issueBypA  (issueBypA),
  .issueBypB  (issueBypB)
);

// File: tb/issue_window_tb_top.sv
`timescale 1ns/1ps
module issue_window_tb_top;

  localparam int NE = 8;
  localparam int IW = 4;
  localparam int OPW = 4;
  localparam int TW = 6;
  localparam int XW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic           allocValid, allocRdyA, allocRdyB, retireValid, repairValid;
  logic [XW-1:0]  allocIdx, retireIdx;
  logic [OPW-1:0] allocOp;
  logic [TW-1:0]  allocDst, allocSrcA, allocSrcB;
  logic [NE-1:0]  repairMask;
  logic [IW-1:0]  issueValid, issueBypA, issueBypB;
  logic [IW*XW-1:0]  issueIdx;
  logic [IW*OPW-1:0] issueOp;
  logic [IW*TW-1:0]  issueDst;

  issue_window dut_i (
    .clk(clk), .rst_n(rst_n),
    .allocValid(allocValid), .allocIdx(allocIdx), .allocOp(allocOp), .allocDst(allocDst),
    .allocSrcA(allocSrcA), .allocRdyA(allocRdyA), .allocSrcB(allocSrcB), .allocRdyB(allocRdyB),
    .retireValid(retireValid), .retireIdx(retireIdx),
    .repairValid(repairValid), .repairMask(repairMask),
    .issueValid(issueValid), .issueIdx(issueIdx), .issueOp(issueOp), .issueDst(issueDst),
    .issueBypA(issueBypA), .issueBypB(issueBypB)
  );

  typedef struct {
    int       n;
    int       idx[IW];
    logic [IW-1:0] bA;
    logic [IW-1:0] bB;
    string    req;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: compares each cycle's slots away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      logic [IW-1:0] vExp;
      e = expQ.pop_front();
      vExp = IW'((1 << e.n) - 1);
      check(issueValid == vExp, e.req, "valid", issueValid, vExp);
      for (int s = 0; s < e.n; s++) begin
        int ai, ad, ao;
        ai = int'(issueIdx[s*XW +: XW]);
        ad = int'(issueDst[s*TW +: TW]);
        ao = int'(issueOp[s*OPW +: OPW]);
        check(ai == e.idx[s] && ad == 32 + e.idx[s] && ao == e.idx[s], e.req,
              $sformatf("slot%0d idx", s), ai, e.idx[s]);
        check(issueBypA[s] == e.bA[s] && issueBypB[s] == e.bB[s], e.req,
              $sformatf("slot%0d byp", s), {issueBypA[s], issueBypB[s]}, {e.bA[s], e.bB[s]});
      end
    end
  end

  task automatic nextCycle();
    @(posedge clk);
    #1;
    allocValid = 0; allocIdx = '0; allocOp = '0; allocDst = '0;
    allocSrcA = '0; allocSrcB = '0; allocRdyA = 0; allocRdyB = 0;
    retireValid = 0; retireIdx = '0; repairValid = 0; repairMask = '0;
  endtask

  // Entry e always gets destination tag 32+e and operation code e
  task automatic alloc(input int idx, input int sa, input bit ra, input int sb, input bit rb);
    allocValid = 1;
    allocIdx = XW'(idx);
    allocOp = OPW'(idx);
    allocDst = TW'(32 + idx);
    allocSrcA = TW'(sa); allocRdyA = ra;
    allocSrcB = TW'(sb); allocRdyB = rb;
  endtask

  task automatic expect_issue(input int n, input int i0, input int i1, input int i2, input int i3,
                              input logic [IW-1:0] bA, input logic [IW-1:0] bB, input string req);
    expItem_t e;
    e.n = n;
    e.idx[0] = i0; e.idx[1] = i1; e.idx[2] = i2; e.idx[3] = i3;
    e.bA = bA; e.bB = bB; e.req = req;
    expQ.push_back(e);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    allocValid = 0; allocIdx = '0; allocOp = '0; allocDst = '0;
    allocSrcA = '0; allocSrcB = '0; allocRdyA = 0; allocRdyB = 0;
    retireValid = 0; retireIdx = '0; repairValid = 0; repairMask = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    nextCycle(); expect_issue(0, 0,0,0,0, 4'b0, 4'b0, "R1 reset empty");
    nextCycle(); alloc(3, 34, 0, 5, 1); expect_issue(0, 0,0,0,0, 0, 0, "R1");
    nextCycle(); alloc(2, 1, 1, 2, 1);  expect_issue(0, 0,0,0,0, 0, 0, "R5 waiting source");
    nextCycle(); alloc(5, 35, 0, 36, 0); expect_issue(1, 2,0,0,0, 0, 0, "R2 ready alloc issues");
    nextCycle(); expect_issue(1, 3,0,0,0, 4'b0001, 0, "R5 R6 woken with bypass");
    nextCycle(); expect_issue(0, 0,0,0,0, 0, 0, "R4 no reissue");
    nextCycle(); alloc(4, 7, 1, 8, 1); expect_issue(0, 0,0,0,0, 0, 0, "R4");
    nextCycle(); expect_issue(1, 4,0,0,0, 0, 0, "R2");
    nextCycle(); expect_issue(1, 5,0,0,0, 4'b0000, 4'b0001, "R6 stale bypass cleared");

    nextCycle(); retireValid = 1; retireIdx = 3'd2; alloc(1, 32, 0, 11, 1); expect_issue(0, 0,0,0,0, 0, 0, "R9");
    nextCycle(); retireValid = 1; retireIdx = 3'd3; alloc(2, 32, 0, 12, 1); expect_issue(0, 0,0,0,0, 0, 0, "R9");
    nextCycle(); retireValid = 1; retireIdx = 3'd4; alloc(3, 32, 0, 13, 1); expect_issue(0, 0,0,0,0, 0, 0, "R9");
    nextCycle(); retireValid = 1; retireIdx = 3'd5; alloc(6, 32, 0, 32, 0); expect_issue(0, 0,0,0,0, 0, 0, "R9");
    nextCycle(); alloc(7, 32, 0, 9, 1);  expect_issue(0, 0,0,0,0, 0, 0, "R5");
    nextCycle(); alloc(4, 32, 0, 14, 1); expect_issue(0, 0,0,0,0, 0, 0, "R5");
    nextCycle(); alloc(0, 1, 1, 2, 1);   expect_issue(0, 0,0,0,0, 0, 0, "R5");
    nextCycle(); expect_issue(1, 0,0,0,0, 0, 0, "R2 producer");
    nextCycle(); expect_issue(4, 1,2,3,4, 4'b1111, 4'b0000, "R3 four lowest");
    nextCycle(); expect_issue(2, 6,7,0,0, 4'b0000, 4'b0000, "R3 remainder R6");

    nextCycle(); repairValid = 1; repairMask = 8'b0000_0001;
    expect_issue(0, 0,0,0,0, 0, 0, "R7 repair blackout");
    nextCycle(); expect_issue(1, 0,0,0,0, 0, 0, "R8 dependents cleared R7");
    nextCycle(); expect_issue(2, 6,7,0,0, 4'b0011, 4'b0001, "R7 reissue after rewake");

    nextCycle(); repairValid = 1; repairMask = 8'b0000_0010; retireValid = 1; retireIdx = 3'd7;
    expect_issue(0, 0,0,0,0, 0, 0, "R7");
    nextCycle(); alloc(5, 38, 0, 10, 1);
    expect_issue(2, 1,6,0,0, 0, 0, "R7 R9 killed reissue retired absent");
    nextCycle(); expect_issue(1, 5,0,0,0, 4'b0001, 0, "R10 alloc capture");
    nextCycle(); expect_issue(0, 0,0,0,0, 0, 0, "R9");

    while (expQ.size() > 0) @(negedge clk);
    #1;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule